// File: doc/BRIEF.md
# Sticky Alarm Status Register

This block holds the eight-bit status byte of a temperature and fan monitoring device. A serial management bus reads the byte. Two bits show the present level of two general-purpose I/O lines. Two flags latch any change on those lines. Two flags latch the high and low temperature alarms. The last two bits follow the remote-diode fault and the critical over-temperature condition directly.

The bus engine supplies a one-cycle read strobe. The byte seen during the strobe cycle is the value the bus returns. The clear rules take effect at the end of that cycle. A transition flag clears on any read. A temperature flag clears only on a read made after its condition has gone away.

An alert output is derived from the sticky flags. Its active level is set by a polarity input, and that input never alters the stored byte.

Top module: `alarm_status_reg`

## Requirements
- R1: Bit 7 and bit 6 show the levels of I/O line A and I/O line B after a two-flop synchronizer. A change at the pin appears on the bit after two rising clock edges.
- R2: A rising or a falling change on line A sets bit 5, and one on line B sets bit 4. The flag is set at the clock edge after the one at which the matching level bit changed.
- R3: Bits 5 and 4 stay set until a read strobe, and clear at the edge that ends the read. A transition that is detected at that same edge leaves its flag set.
- R4: Bit 3 is set while the high-temperature condition is asserted, and bit 2 is set while the low-temperature condition is asserted, one edge after the condition is seen. Each stays set after its condition drops.
- R5: A read while a temperature condition is still asserted leaves its flag set. The first read after the condition drops clears the flag.
- R6: Bit 1 follows the diode-fault input and bit 0 follows the critical-threshold input, each one edge late and neither sticky.
- R7: During the strobe cycle the byte still holds its pre-read value, so the read returns the flags as they were before the clear.
- R8: A synchronous active-high reset clears all eight bits.
- R9: The alert output, one edge after the flags, is at the polarity level when any of bits 5 to 2 is set and at its inverse otherwise. The polarity input has no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| io_a_pin | input | 1 | Asynchronous I/O line A |
| io_b_pin | input | 1 | Asynchronous I/O line B |
| temp_hi_cond | input | 1 | High-temperature alarm condition |
| temp_lo_cond | input | 1 | Low-temperature alarm condition |
| diode_fault | input | 1 | Remote-diode fault condition |
| crit_over | input | 1 | Critical threshold exceeded |
| rd_stb | input | 1 | One-cycle status read strobe |
| alert_pol | input | 1 | Active level of the alert output |
| status_byte | output | 8 | Status byte {io_a, io_b, tr_a, tr_b, hi, lo, diode, crit} |
| alert_out | output | 1 | Alert pin level derived from the sticky flags |

## Verification
The temperature section is driven through a table of condition and strobe sequences. These tell apart a read made during a fault from one made after it, a set that arrives together with a read, and the live bits from the sticky ones. Directed cases drive rising and falling changes on each I/O line. They separate the delay of the level bit from that of the flag, and they place a read on the very edge where a transition is detected. Flipping the polarity with flags set and with flags clear shows that it moves only the alert pin. A reset in mid-run must clear every bit.

// File: rtl/alarm_stat_pkg.sv
package alarm_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_IO_A = 7;
  localparam int BIT_IO_B = 6;
  localparam int BIT_TR_A = 5;
  localparam int BIT_TR_B = 4;
  localparam int BIT_HI   = 3;
  localparam int BIT_LO   = 2;
  localparam int BIT_DIO  = 1;
  localparam int BIT_CRIT = 0;
  localparam int N_IO     = 2;
  localparam int N_STICKY = 4;
endpackage

// File: rtl/io_edge_sync.sv
module io_edge_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] edge_o
);
  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], pin_i[i]};
        prev  <= chain[LAST];
      end
    end
    assign level_o[i] = chain[LAST];
    assign edge_o[i]  = chain[LAST] ^ prev;
  end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] keep;

  always_comb keep = rd_i ? '0 : flag_o;

  always_ff @(posedge clk) begin
    if (rst) flag_o <= '0;
    else     flag_o <= set_i | keep;
  end
endmodule

// File: rtl/alert_drive.sv
module alert_drive #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flag_i,
  input  logic         pol_i,
  output logic         alert_o
);
  logic any_set;

  always_comb any_set = |flag_i;

  always_ff @(posedge clk) begin
    if (rst) alert_o <= ~pol_i;
    else     alert_o <= any_set ? pol_i : ~pol_i;
  end
endmodule

// File: rtl/alarm_status_reg.sv
module alarm_status_reg
  import alarm_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_a_pin,
  input  logic              io_b_pin,
  input  logic              temp_hi_cond,
  input  logic              temp_lo_cond,
  input  logic              diode_fault,
  input  logic              crit_over,
  input  logic              rd_stb,
  input  logic              alert_pol,
  output logic [STAT_W-1:0] status_byte,
  output logic              alert_out
);
  logic [N_IO-1:0]     io_level;
  logic [N_IO-1:0]     io_edge;
  logic [N_STICKY-1:0] sticky_set;
  logic [N_STICKY-1:0] sticky_q;
  logic                diode_q;
  logic                crit_q;

  io_edge_sync #(.N(N_IO), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_i   ({io_a_pin, io_b_pin}),
    .level_o (io_level),
    .edge_o  (io_edge)
  );

  // order: tr_a, tr_b, hi, lo
  always_comb sticky_set = {io_edge, temp_hi_cond, temp_lo_cond};

  sticky_bank #(.W(N_STICKY)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (sticky_set),
    .rd_i   (rd_stb),
    .flag_o (sticky_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      diode_q <= 1'b0;
      crit_q  <= 1'b0;
    end else begin
      diode_q <= diode_fault;
      crit_q  <= crit_over;
    end
  end

  alert_drive #(.W(N_STICKY)) u_alert (
    .clk     (clk),
    .rst     (rst),
    .flag_i  (sticky_q),
    .pol_i   (alert_pol),
    .alert_o (alert_out)
  );

  assign status_byte = {io_level, sticky_q, diode_q, crit_q};
endmodule

// File: rtl/alarm_status_chk.sv
module alarm_status_chk
  import alarm_stat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              temp_hi_cond,
  input logic              rd_stb,
  input logic              alert_pol,
  input logic [STAT_W-1:0] status_byte,
  input logic              alert_out
);
  p_tr_a_set_r2: assert property (@(posedge clk) disable iff (rst)
    (status_byte[BIT_IO_A] != $past(status_byte[BIT_IO_A])) |=> status_byte[BIT_TR_A]);

  p_tr_b_set_r2: assert property (@(posedge clk) disable iff (rst)
    (status_byte[BIT_IO_B] != $past(status_byte[BIT_IO_B])) |=> status_byte[BIT_TR_B]);

  p_tr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (status_byte[BIT_TR_A] && !rd_stb) |=> status_byte[BIT_TR_A]);

  p_hi_set_r4: assert property (@(posedge clk) disable iff (rst)
    temp_hi_cond |=> status_byte[BIT_HI]);

  p_hi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (status_byte[BIT_HI] && !rd_stb) |=> status_byte[BIT_HI]);

  p_alert_level_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (alert_out == ($past(|status_byte[BIT_TR_A:BIT_LO]) ? $past(alert_pol)
                                                                  : !$past(alert_pol))));
endmodule

bind alarm_status_reg alarm_status_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .temp_hi_cond (temp_hi_cond),
  .rd_stb       (rd_stb),
  .alert_pol    (alert_pol),
  .status_byte  (status_byte),
  .alert_out    (alert_out)
);

// File: tb/test_alarm_status_reg.sv
`timescale 1ns/1ps
module test_alarm_status_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_a = 1'b0, io_b = 1'b0, hi = 1'b0, lo = 1'b0, dio = 1'b0, crit = 1'b0;
  logic rd = 1'b0, pol = 1'b1;
  logic [7:0] st;
  logic alert;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alarm_status_reg i_alarm_status_reg (
    .clk(clk), .rst(rst), .io_a_pin(io_a), .io_b_pin(io_b),
    .temp_hi_cond(hi), .temp_lo_cond(lo), .diode_fault(dio), .crit_over(crit),
    .rd_stb(rd), .alert_pol(pol), .status_byte(st), .alert_out(alert)
  );

  // {hi, lo, dio, crit, rd, expected status[3:0] after the edge}
  localparam logic [8:0] VEC [10] = '{
    9'b00000_0000,
    9'b10000_1000,
    9'b10001_1000,  // read during fault keeps flag
    9'b00000_1000,  // sticky after removal
    9'b00001_0000,  // read after removal clears
    9'b01100_0110,
    9'b00010_0101,  // lo sticky, diode live gone, crit live
    9'b00001_0000,
    9'b11001_1100,  // set together with read
    9'b00001_0000
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
    end
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R8 reset byte", st, 8'h00);
    chk("R9 alert idle pol=1", {7'd0, alert}, 8'h00);
    @(negedge clk) rst = 1'b0;

    // table walk: temperature, diode and critical bits
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      {hi, lo, dio, crit, rd} = VEC[v][8:4];
      step(1);
      chk($sformatf("R4/R5/R6 vec%0d", v), {4'd0, st[3:0]}, {4'd0, VEC[v][3:0]});
    end
    @(negedge clk) {hi, lo, dio, crit, rd} = 5'd0;

    // R7: the byte holds its value during the strobe cycle
    @(negedge clk) hi = 1'b1;
    @(negedge clk) begin hi = 1'b0; rd = 1'b1; end
    #1 chk("R7 pre-read value visible", st, 8'b0000_1000);
    step(1);
    chk("R5 cleared after read", st, 8'h00);
    @(negedge clk) rd = 1'b0;

    // R1/R2: rising change on line A
    @(negedge clk) io_a = 1'b1;
    step(1);
    chk("R1 one edge not yet", st, 8'h00);
    step(1);
    chk("R1 level after two edges", st, 8'b1000_0000);
    step(1);
    chk("R2 rising flag A", st, 8'b1010_0000);
    chk("R9 alert with flag pol=1", {7'd0, alert}, 8'h00);
    step(1);
    chk("R9 alert asserted pol=1", {7'd0, alert}, 8'h01);
    @(negedge clk) pol = 1'b0;
    step(1);
    chk("R9 alert asserted pol=0", {7'd0, alert}, 8'h00);
    chk("R9 polarity leaves byte", st, 8'b1010_0000);
    @(negedge clk) rd = 1'b1;
    step(1);
    chk("R3 read clears flag A", st, 8'b1000_0000);
    @(negedge clk) rd = 1'b0;
    step(1);
    chk("R9 alert idle pol=0", {7'd0, alert}, 8'h01);
    @(negedge clk) pol = 1'b1;

    // R2: falling change on line A
    @(negedge clk) io_a = 1'b0;
    step(3);
    chk("R2 falling flag A", st, 8'b0010_0000);
    @(negedge clk) rd = 1'b1;
    step(1);
    @(negedge clk) rd = 1'b0;

    // R3: transition on line B detected at the same edge as a read
    @(negedge clk) io_b = 1'b1;
    step(2);
    chk("R1 level B", st, 8'b0100_0000);
    @(negedge clk) rd = 1'b1;
    step(1);
    chk("R3 coincident set survives", st, 8'b0101_0000);
    @(negedge clk) rd = 1'b0;
    step(2);
    chk("R3 flag B held", st, 8'b0101_0000);

    // R8: mid-run reset
    @(negedge clk) begin hi = 1'b1; crit = 1'b1; end
    step(1);
    @(negedge clk) begin rst = 1'b1; hi = 1'b0; crit = 1'b0; io_b = 1'b0; end
    step(3);
    chk("R8 mid-run reset", st, 8'h00);
    @(negedge clk) rst = 1'b0;
    step(3);
    chk("R8 quiet after reset", st, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule